// File: doc/BRIEF.md
# Banked FIR Coefficient Store

This block holds the coefficients for a dual FIR engine built from two cells, A and B, each with four multipliers. That gives eight multiplier banks. Each bank keeps 32 coefficient sets of 10 bits each. A host write port loads one coefficient per clock. The 9-bit write address is split into four fields: a region bit, a set index, a cell select and a multiplier index. A write strobe qualifies the write.

On the filter side, a 5-bit set-select input chooses one set. That set drives all eight coefficient outputs at once, one cycle after the select is sampled. The select may change on every clock, so a polyphase filter can step through its phases at full rate.

Each bank is a small memory that can be inferred as block RAM, paired with a per-set valid bit. A reset clears the valid bits, so every stored coefficient reads back as zero until the host writes it.

Top module: `fir_coef_store`

## Requirements
- R1: While reset is high and after it is released, every coefficient output is zero, and every set reads as zero until it is written again.
- R2: A write with `wr_en` high and address bit 8 at 1 stores `wr_data` at the rising edge. The destination is bank index `{addr[2], addr[1:0]}` (cell times four plus multiplier) and set `addr[7:3]`.
- R3: A write with address bit 8 at 0 changes no stored coefficient.
- R4: With `wr_en` low, no stored coefficient changes, whatever the address and data are.
- R5: Bank k drives `coef_out[k*10 +: 10]`, where k = cell*4 + multiplier, cell A = 0 and cell B = 1.
- R6: After each rising edge, `coef_out` shows the eight coefficients of the set that `set_sel` held at that edge. A different set may be selected on every clock.
- R7: A write to address 0x10D lands in cell B, multiplier 1, set 1, which is bank 5, bits 59:50.
- R8: If a set is written and selected on the same edge, the output after that edge shows the old contents. The new value appears after the next edge that selects the same set.
- R9: A write changes exactly one bank and one set. All other locations keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 9 | Write address: bit 8 region, 7:3 set, 2 cell, 1:0 multiplier |
| wr_data | input | 10 | Coefficient to store |
| set_sel | input | 5 | Set that drives all eight outputs |
| coef_out | output | 80 | Eight registered coefficients, bank k at bits k*10 +: 10 |

## Verification
The assertions assume that `wr_addr` and `wr_data` are known whenever `wr_en` is high, and that `set_sel` is known on every clock outside reset. The bench drives all of these inputs on the falling edge from full-range random values, so it never presents an unknown value at a rising edge.

The hold check assumes that no write took effect on the previous edge. The visibility check takes its window from the write edge, with reset low on both edges. The random phase mixes low-region addresses, an idle strobe and a set select that changes every cycle, so that every path into the memory is exercised.

// File: rtl/fir_coef_pkg.sv
package fir_coef_pkg;
  localparam int unsigned CELLS_DEF   = 2;
  localparam int unsigned MULTS_DEF   = 4;
  localparam int unsigned SETS_DEF    = 32;
  localparam int unsigned COEF_W_DEF  = 10;
  localparam int unsigned ADDR_W_DEF  = 9;
endpackage

// File: rtl/coef_wr_decode.sv
module coef_wr_decode #(
  parameter int unsigned NUM_CELLS = 2,
  parameter int unsigned MULTS     = 4,
  parameter int unsigned NUM_SETS  = 32,
  parameter int unsigned ADDR_W    = 9,
  localparam int unsigned MULT_W    = $clog2(MULTS),
  localparam int unsigned CELL_W    = $clog2(NUM_CELLS),
  localparam int unsigned SET_W     = $clog2(NUM_SETS),
  localparam int unsigned IDX_W     = MULT_W + CELL_W,
  localparam int unsigned NUM_BANKS = NUM_CELLS * MULTS
) (
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  output logic [NUM_BANKS-1:0] bank_we,
  output logic [SET_W-1:0]     wr_set
);
  logic             region_hit;
  logic [IDX_W-1:0] bank_idx;

  // Cell bit sits just above the multiplier bits, so the low field is cell*MULTS+mult.
  assign region_hit = wr_addr[ADDR_W-1];
  assign bank_idx   = wr_addr[IDX_W-1:0];
  assign wr_set     = wr_addr[IDX_W +: SET_W];

  always_comb begin
    bank_we = '0;
    if (wr_en && region_hit) begin
      bank_we[bank_idx] = 1'b1;
    end
  end
endmodule

// File: rtl/coef_bank.sv
module coef_bank #(
  parameter int unsigned NUM_SETS = 32,
  parameter int unsigned COEF_W   = 10,
  localparam int unsigned SET_W   = $clog2(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [COEF_W-1:0] wr_data,
  input  logic [SET_W-1:0]  rd_set,
  output logic [COEF_W-1:0] coef
);
  logic [COEF_W-1:0]   mem [NUM_SETS];
  logic [NUM_SETS-1:0] set_valid;
  logic [COEF_W-1:0]   rd_q;
  logic                rd_v;

  // Plain synchronous RAM, read-first, no reset: suits block RAM inference.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[wr_set] <= wr_data;
    end
    rd_q <= mem[rd_set];
  end

  // Valid flags carry the reset; a cleared flag masks the RAM word to zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      set_valid <= '0;
      rd_v      <= 1'b0;
    end else begin
      if (we) begin
        set_valid[wr_set] <= 1'b1;
      end
      rd_v <= set_valid[rd_set];
    end
  end

  assign coef = rd_v ? rd_q : '0;

  // R1: the first cycle out of reset shows a zero coefficient
  p_zero_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> coef == '0);

  // R2: a written word is visible when the same set is selected on the next edge
  p_write_visible_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && !$past(rst) && rd_set == $past(wr_set)) |=> coef == $past(wr_data, 2));
endmodule

// File: rtl/fir_coef_store.sv
module fir_coef_store
  import fir_coef_pkg::*;
#(
  parameter int unsigned NUM_CELLS = CELLS_DEF,
  parameter int unsigned MULTS     = MULTS_DEF,
  parameter int unsigned NUM_SETS  = SETS_DEF,
  parameter int unsigned COEF_W    = COEF_W_DEF,
  parameter int unsigned ADDR_W    = ADDR_W_DEF,
  localparam int unsigned SET_W     = $clog2(NUM_SETS),
  localparam int unsigned NUM_BANKS = NUM_CELLS * MULTS
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [COEF_W-1:0]           wr_data,
  input  logic [SET_W-1:0]            set_sel,
  output logic [NUM_BANKS*COEF_W-1:0] coef_out
);
  logic [NUM_BANKS-1:0] bank_we;
  logic [SET_W-1:0]     wr_set;

  coef_wr_decode #(
    .NUM_CELLS(NUM_CELLS),
    .MULTS    (MULTS),
    .NUM_SETS (NUM_SETS),
    .ADDR_W   (ADDR_W)
  ) i_decode (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .bank_we(bank_we),
    .wr_set (wr_set)
  );

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic [COEF_W-1:0] bank_coef;

    coef_bank #(
      .NUM_SETS(NUM_SETS),
      .COEF_W  (COEF_W)
    ) i_bank (
      .clk    (clk),
      .rst    (rst),
      .we     (bank_we[k]),
      .wr_set (wr_set),
      .wr_data(wr_data),
      .rd_set (set_sel),
      .coef   (bank_coef)
    );

    // R5: bank k owns its own slice of the output bus
    assign coef_out[k*COEF_W +: COEF_W] = bank_coef;
  end

  // R9: a write reaches at most one bank
  p_single_bank_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_we));

  // R3: a low region bit keeps all banks untouched
  p_region_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_addr[ADDR_W-1] |-> bank_we == '0);

  // R4: no strobe, no bank write
  p_strobe_gate_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> bank_we == '0);

  // R6: an unchanged select with no write on the prior edge holds the outputs
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (set_sel == $past(set_sel) && !$past(wr_en) && !$past(rst)) |=> $stable(coef_out));
endmodule

// File: tb/test_fir_coef_store.sv
`timescale 1ns/1ps
module test_fir_coef_store;
  localparam int BANKS = 8;
  localparam int SETS  = 32;
  localparam int CW    = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [8:0]      wr_addr = '0;
  logic [CW-1:0]   wr_data = '0;
  logic [4:0]      set_sel = '0;
  logic [BANKS*CW-1:0] coef_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [CW-1:0]       model [BANKS][SETS];
  logic [BANKS*CW-1:0] exp_q;
  bit                  have_exp = 1'b0;
  string               pend_tag;

  always #5 clk = ~clk;

  fir_coef_store i_fir_coef_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .set_sel (set_sel),
    .coef_out(coef_out)
  );

  function automatic logic [BANKS*CW-1:0] expect_row(input bit r, input logic [4:0] s);
    logic [BANKS*CW-1:0] v;
    for (int k = 0; k < BANKS; k++) v[k*CW +: CW] = r ? '0 : model[k][s];
    return v;
  endfunction

  task automatic check_bank(input int k, input logic [CW-1:0] want, input string tag);
    checks++;
    if (coef_out[k*CW +: CW] !== want) begin
      failures++;
      $display("FAIL %s bank %0d actual=%h expected=%h", tag, k, coef_out[k*CW +: CW], want);
    end
  endtask

  // Called at a falling edge: checks the pending expectation, then drives one cycle.
  task automatic step(input bit r, input bit we, input logic [8:0] a,
                      input logic [CW-1:0] d, input logic [4:0] s, input string tag);
    if (have_exp) begin
      checks++;
      if (coef_out !== exp_q) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", pend_tag, coef_out, exp_q);
      end
    end
    rst = r; wr_en = we; wr_addr = a; wr_data = d; set_sel = s;
    exp_q = expect_row(r, s);
    if (r) begin
      for (int k = 0; k < BANKS; k++)
        for (int j = 0; j < SETS; j++) model[k][j] = '0;
    end else if (we && a[8]) begin
      model[{a[2], a[1:0]}][a[7:3]] = d;
    end
    have_exp = 1'b1;
    pend_tag = tag;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'd20240611);
    for (int k = 0; k < BANKS; k++)
      for (int j = 0; j < SETS; j++) model[k][j] = '0;
    @(negedge clk);
    // R1: reset then sweep all sets, expecting zeros
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 9'h000, '0, 5'd0, "R1 reset");
    for (int i = 0; i < SETS; i++) step(1'b0, 1'b0, 9'h000, '0, 5'(i), "R1 sweep");
    // R7: address 0x10D lands in bank 5 set 1
    step(1'b0, 1'b1, 9'h10D, 10'h2AB, 5'd0, "R7");
    step(1'b0, 1'b0, 9'h000, '0, 5'd1, "R7");
    step(1'b0, 1'b0, 9'h000, '0, 5'd1, "R7");
    check_bank(5, 10'h2AB, "R5 R7");
    check_bank(1, 10'h000, "R5");
    // R3: low region bit writes nothing
    step(1'b0, 1'b1, 9'h00D, 10'h155, 5'd1, "R3");
    step(1'b0, 1'b0, 9'h000, '0, 5'd1, "R3");
    step(1'b0, 1'b0, 9'h000, '0, 5'd1, "R3");
    check_bank(5, 10'h2AB, "R3");
    // R4: strobe low writes nothing
    step(1'b0, 1'b0, 9'h10D, 10'h3FF, 5'd1, "R4");
    step(1'b0, 1'b0, 9'h000, '0, 5'd1, "R4");
    step(1'b0, 1'b0, 9'h000, '0, 5'd1, "R4");
    check_bank(5, 10'h2AB, "R4");
    // R8: write and select the same set on one edge
    step(1'b0, 1'b1, 9'h118, 10'h0F0, 5'd3, "R8 old");
    step(1'b0, 1'b0, 9'h000, '0, 5'd3, "R8 new");
    step(1'b0, 1'b0, 9'h000, '0, 5'd3, "R8 new");
    check_bank(0, 10'h0F0, "R8");
    // R6: select changes every clock
    for (int i = 0; i < 64; i++) step(1'b0, 1'b0, 9'h000, '0, 5'(31 - (i % 32)), "R6");
    // R2 R6 R9: random writes and selects
    for (int i = 0; i < 3000; i++) begin
      logic [8:0] a;
      a = 9'($urandom);
      a[8] = ($urandom % 8) != 0;
      step(1'b0, 1'($urandom), a, 10'($urandom), 5'($urandom), "R2 R6 R9");
    end
    // R1: a second reset clears everything written
    step(1'b1, 1'b0, 9'h000, '0, 5'd0, "R1 rereset");
    for (int i = 0; i < SETS; i++) step(1'b0, 1'b0, 9'h000, '0, 5'(i), "R1 cleared");
    step(1'b0, 1'b0, 9'h000, '0, 5'd0, "R1 cleared");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule